// File: doc/BRIEF.md
# Compare-Clear and Fast-PWM Timer

This block is a 16-bit up-counting timer that drives a single waveform pin. A prescaler divides the input clock into count ticks, and the counter advances by one on each tick. Two families of operation are supported. In compare-clear mode the counter runs from zero up to a TOP value and then restarts. TOP is taken either from compare register A or from a separate capture/TOP register. In single-slope fast PWM mode, TOP always comes from compare register A, and writes to that register are double buffered.

Three sticky status flags are provided: TOP reached via compare A, TOP reached via the capture register, and counter overflow. Each flag is cleared by writing a one to its bit of the clear field. The pin toggles on every TOP match in compare-clear mode. In fast PWM mode it is set at the start of each period and cleared after the count passes a duty value.

Top module: `ctc_pwm_timer`

## Requirements
- R1: `clk_sel` encodes the clock divider: 1 gives /1, 2 gives /8, 3 gives /64, 4 gives /256 and 5 gives /1024. After leaving the stopped state, the count advances once every N clock edges, so after k edges `count` equals k/N (integer division).
- R2: `clk_sel` values 0, 6 and 7 stop the timer. `count` holds its value and no flag is raised.
- R3: `mode` encoding: 00 is compare-clear with TOP from compare A, 01 is compare-clear with TOP from the capture register, and 10 or 11 is fast PWM with TOP from compare A. On a tick where `count` equals TOP, the count goes to 0; on any other tick it increments.
- R4: In compare-clear mode, a write to compare A or to the capture register takes effect at once and applies to the comparison on the next tick.
- R5: If TOP is written below the current count in compare-clear mode, the counter keeps counting up to 0xFFFF, wraps to 0, and only then can it match.
- R6: `flag_ovf` is set on the tick on which `count` goes from 0xFFFF to 0.
- R7: A TOP match raises `flag_cmpa` when TOP comes from compare A (modes 00, 10, 11), and raises `flag_top_cap` when TOP comes from the capture register (mode 01).
- R8: In compare-clear mode with `out_en`=1, `wave_out` inverts on each TOP match, which gives a period of 2·N·(TOP+1) clocks. A TOP of 0 at /1 therefore toggles on every clock. With `out_en`=0, `wave_out` stays 0.
- R9: In fast PWM mode, a compare A write goes to a buffer. The buffer is copied into the active TOP on the tick on which the count wraps from TOP to 0.
- R10: In fast PWM mode with `out_en`=1, `wave_out` is set on each wrap to 0 and cleared on the tick on which `count` leaves `duty_b`. After the first wrap, it is therefore high while `count` is at or below `duty_b`.
- R11: `flag_clr` bit 0 clears `flag_cmpa`, bit 1 clears `flag_top_cap` and bit 2 clears `flag_ovf`. A flag being set in the same cycle wins over a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_sel | input | 3 | Divider select, 0/6/7 stop |
| mode | input | 2 | Operating mode select |
| out_en | input | 1 | Enable waveform on `wave_out` |
| cmpa_we | input | 1 | Compare A write strobe |
| cmpa_wdata | input | 16 | Compare A write value |
| cap_we | input | 1 | Capture/TOP register write strobe |
| cap_wdata | input | 16 | Capture/TOP register write value |
| duty_b | input | 16 | Fast PWM duty compare value |
| flag_clr | input | 3 | Write-one-to-clear for the three flags |
| count | output | 16 | Current counter value |
| wave_out | output | 1 | Waveform pin |
| flag_cmpa | output | 1 | TOP reached via compare A |
| flag_top_cap | output | 1 | TOP reached via capture register |
| flag_ovf | output | 1 | Counter wrapped from 0xFFFF |

## Verification
The assertions check several properties on every cycle. A stopped timer holds its count and raises no flag. A tick in compare-clear mode either increments the count or clears it at TOP. A 0xFFFF tick always leaves the overflow flag set, and a clear without a coincident set drops that flag. A disabled pin stays low, and a fast PWM wrap sets the pin. Other behaviours are only visible in the bench scenarios: the exact divider rates, the immediate effect of a TOP write, the long run through 0xFFFF after a missed match, the moment a buffered TOP becomes active, and the duty shape of the PWM waveform.

// File: rtl/wt_pkg.sv
package wt_pkg;

    localparam int PS_W = 10;

    typedef enum logic [1:0] {
        MODE_CTC_A   = 2'b00,
        MODE_CTC_CAP = 2'b01,
        MODE_PWM     = 2'b10,
        MODE_PWM_ALT = 2'b11
    } wt_mode_e;

    typedef struct packed {
        logic ovf;
        logic cap;
        logic cmpa;
    } wt_flags_t;

    function automatic logic is_pwm(input wt_mode_e m);
        return m[1];
    endfunction

    function automatic logic presc_run(input logic [2:0] sel);
        return (sel >= 3'd1) && (sel <= 3'd5);
    endfunction

    function automatic logic [PS_W-1:0] presc_mask(input logic [2:0] sel);
        logic [PS_W-1:0] m;
        case (sel)
            3'd2:    m = PS_W'(7);
            3'd3:    m = PS_W'(63);
            3'd4:    m = PS_W'(255);
            3'd5:    m = PS_W'(1023);
            default: m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/wt_prescaler.sv
module wt_prescaler
    import wt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] sel,
    output logic       tick
);
    logic [PS_W-1:0] pc;
    logic [PS_W-1:0] mask;
    logic            run;

    assign run  = presc_run(sel);
    assign mask = presc_mask(sel);
    assign tick = run && ((pc & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || !run) pc <= '0;
        else             pc <= pc + PS_W'(1);
    end
endmodule

// File: rtl/wt_topreg.sv
module wt_topreg
    import wt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  wt_mode_e     mode,
    input  logic         cmpa_we,
    input  logic [W-1:0] cmpa_wdata,
    input  logic         cap_we,
    input  logic [W-1:0] cap_wdata,
    input  logic         wrap,
    output logic [W-1:0] top_act
);
    logic [W-1:0] cmpa_buf;
    logic [W-1:0] cmpa_act;
    logic [W-1:0] cap_reg;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmpa_buf <= '0;
            cmpa_act <= '0;
            cap_reg  <= '0;
        end else begin
            if (cmpa_we) cmpa_buf <= cmpa_wdata;
            if (cap_we)  cap_reg  <= cap_wdata;
            if (!is_pwm(mode)) begin
                if (cmpa_we) cmpa_act <= cmpa_wdata;
            end else if (wrap) begin
                cmpa_act <= cmpa_buf;
            end
        end
    end

    assign top_act = (mode == MODE_CTC_CAP) ? cap_reg : cmpa_act;
endmodule

// File: rtl/wt_core.sv
module wt_core
    import wt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  wt_mode_e     mode,
    input  logic         out_en,
    input  logic [W-1:0] top_act,
    input  logic [W-1:0] duty,
    input  wt_flags_t    clr,
    output logic [W-1:0] count,
    output logic         wrap,
    output logic         wave,
    output wt_flags_t    flags
);
    logic      at_top;
    logic      at_max;
    wt_flags_t set_v;

    assign at_top = (count == top_act);
    assign at_max = (count == {W{1'b1}});
    assign wrap   = tick && at_top;

    always_comb begin
        set_v      = '0;
        set_v.cmpa = wrap && (mode != MODE_CTC_CAP);
        set_v.cap  = wrap && (mode == MODE_CTC_CAP);
        set_v.ovf  = tick && at_max;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            flags <= '0;
            wave  <= 1'b0;
        end else begin
            if (tick) count <= at_top ? '0 : count + W'(1);
            flags <= (flags & ~clr) | set_v;
            if (!out_en) begin
                wave <= 1'b0;
            end else if (is_pwm(mode)) begin
                if (wrap)                        wave <= 1'b1;
                else if (tick && count == duty)  wave <= 1'b0;
            end else if (wrap) begin
                wave <= ~wave;
            end
        end
    end
endmodule

// File: rtl/ctc_pwm_timer.sv
module ctc_pwm_timer
    import wt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [2:0]   clk_sel,
    input  logic [1:0]   mode,
    input  logic         out_en,
    input  logic         cmpa_we,
    input  logic [W-1:0] cmpa_wdata,
    input  logic         cap_we,
    input  logic [W-1:0] cap_wdata,
    input  logic [W-1:0] duty_b,
    input  logic [2:0]   flag_clr,
    output logic [W-1:0] count,
    output logic         wave_out,
    output logic         flag_cmpa,
    output logic         flag_top_cap,
    output logic         flag_ovf
);
    wt_mode_e     mode_e;
    logic         tick;
    logic         wrap;
    logic [W-1:0] top_act;
    wt_flags_t    flags;

    assign mode_e = wt_mode_e'(mode);

    wt_prescaler u_ps (
        .clk  (clk),
        .rst  (rst),
        .sel  (clk_sel),
        .tick (tick)
    );

    wt_topreg #(.W(W)) u_top (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode_e),
        .cmpa_we    (cmpa_we),
        .cmpa_wdata (cmpa_wdata),
        .cap_we     (cap_we),
        .cap_wdata  (cap_wdata),
        .wrap       (wrap),
        .top_act    (top_act)
    );

    wt_core #(.W(W)) u_core (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .mode    (mode_e),
        .out_en  (out_en),
        .top_act (top_act),
        .duty    (duty_b),
        .clr     (wt_flags_t'(flag_clr)),
        .count   (count),
        .wrap    (wrap),
        .wave    (wave_out),
        .flags   (flags)
    );

    assign flag_cmpa    = flags.cmpa;
    assign flag_top_cap = flags.cap;
    assign flag_ovf     = flags.ovf;
endmodule

// File: rtl/ctc_pwm_timer_checker.sv
module ctc_pwm_timer_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic [2:0]   clk_sel,
    input logic         pwm_mode,
    input logic         out_en,
    input logic [2:0]   flag_clr,
    input logic [W-1:0] count,
    input logic         wave_out,
    input logic         flag_cmpa,
    input logic         flag_top_cap,
    input logic         flag_ovf,
    input logic         tick,
    input logic [W-1:0] top_act
);
    logic stopped;
    assign stopped = (clk_sel == 3'd0) || (clk_sel > 3'd5);

    a_r2_stop_hold: assert property (@(posedge clk) disable iff (rst)
        stopped |=> count == $past(count));

    a_r2_stop_noflag: assert property (@(posedge clk) disable iff (rst)
        stopped |=> !$rose(flag_cmpa) && !$rose(flag_top_cap) && !$rose(flag_ovf));

    a_r3_ctc_step: assert property (@(posedge clk) disable iff (rst)
        (tick && !pwm_mode && count != top_act) |=> count == $past(count) + W'(1));

    a_r3_clear_at_top: assert property (@(posedge clk) disable iff (rst)
        (tick && count == top_act) |=> count == '0);

    a_r6_ovf_set: assert property (@(posedge clk) disable iff (rst)
        (tick && count == {W{1'b1}}) |=> flag_ovf);

    a_r11_ovf_clear: assert property (@(posedge clk) disable iff (rst)
        (flag_clr[2] && !(tick && count == {W{1'b1}})) |=> !flag_ovf);

    a_r8_pin_off: assert property (@(posedge clk) disable iff (rst)
        !out_en |=> !wave_out);

    a_r10_pwm_set: assert property (@(posedge clk) disable iff (rst)
        (tick && pwm_mode && out_en && count == top_act) |=> wave_out);
endmodule

bind ctc_pwm_timer ctc_pwm_timer_checker #(.W(W)) chk (
    .clk          (clk),
    .rst          (rst),
    .clk_sel      (clk_sel),
    .pwm_mode     (mode[1]),
    .out_en       (out_en),
    .flag_clr     (flag_clr),
    .count        (count),
    .wave_out     (wave_out),
    .flag_cmpa    (flag_cmpa),
    .flag_top_cap (flag_top_cap),
    .flag_ovf     (flag_ovf),
    .tick         (tick),
    .top_act      (top_act)
);

// File: tb/ctc_pwm_timer_test.sv
module ctc_pwm_timer_test;
    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  clk_sel;
    logic [1:0]  mode;
    logic        out_en;
    logic        cmpa_we;
    logic [15:0] cmpa_wdata;
    logic        cap_we;
    logic [15:0] cap_wdata;
    logic [15:0] duty_b;
    logic [2:0]  flag_clr;
    logic [15:0] count;
    logic        wave_out;
    logic        flag_cmpa;
    logic        flag_top_cap;
    logic        flag_ovf;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    ctc_pwm_timer uut (
        .clk(clk), .rst(rst), .clk_sel(clk_sel), .mode(mode), .out_en(out_en),
        .cmpa_we(cmpa_we), .cmpa_wdata(cmpa_wdata), .cap_we(cap_we),
        .cap_wdata(cap_wdata), .duty_b(duty_b), .flag_clr(flag_clr),
        .count(count), .wave_out(wave_out), .flag_cmpa(flag_cmpa),
        .flag_top_cap(flag_top_cap), .flag_ovf(flag_ovf)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; clk_sel = 3'd0; mode = 2'b00; out_en = 1'b0;
        cmpa_we = 1'b0; cmpa_wdata = '0; cap_we = 1'b0; cap_wdata = '0;
        duty_b = '0; flag_clr = '0;
        step(2);
        rst = 1'b0;
    endtask

    task automatic wr_a(input logic [15:0] v);
        cmpa_we = 1'b1; cmpa_wdata = v;
        step(1);
        cmpa_we = 1'b0;
    endtask

    initial begin
        #(190000 * 5);
        n_err++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        // reset state
        do_reset();
        chk("R3 reset count", count, 0);
        chk("R8 reset pin", wave_out, 0);
        chk("R11 reset flags", {flag_ovf, flag_top_cap, flag_cmpa}, 0);

        // R3 R8 R7: compare-clear sweep over small TOP values, /1
        for (int top = 0; top < 6; top++) begin
            do_reset();
            out_en = (top != 3);
            wr_a(16'(top));
            clk_sel = 3'd1;
            for (int k = 1; k <= 3 * (top + 1); k++) begin
                step(1);
                chk("R3 ctc count", count, k % (top + 1));
                chk("R8 toggle pin", wave_out, out_en ? ((k / (top + 1)) % 2) : 0);
                chk("R7 cmpa flag", flag_cmpa, (k >= top + 1) ? 1 : 0);
            end
        end

        // R7 R3: TOP from capture register
        do_reset();
        mode = 2'b01;
        wr_a(16'hFFFF);
        cap_we = 1'b1; cap_wdata = 16'd4; step(1); cap_we = 1'b0;
        clk_sel = 3'd1;
        step(4);
        chk("R3 cap top count", count, 4);
        chk("R7 cap flag before", flag_top_cap, 0);
        step(1);
        chk("R3 cap top clear", count, 0);
        chk("R7 cap flag", flag_top_cap, 1);
        chk("R7 cmpa flag not set", flag_cmpa, 0);

        // R4 R11: immediate TOP write, then clear flag
        do_reset();
        wr_a(16'd100);
        clk_sel = 3'd1;
        step(20);
        wr_a(16'd40);
        chk("R4 count after write", count, 21);
        step(19);
        chk("R4 count at new top", count, 40);
        chk("R4 no flag yet", flag_cmpa, 0);
        step(1);
        chk("R4 clear at new top", count, 0);
        chk("R7 flag at new top", flag_cmpa, 1);
        flag_clr = 3'b001; step(1); flag_clr = 3'b000;
        chk("R11 cmpa cleared", flag_cmpa, 0);

        // R5 R6 R11: missed match runs through 0xFFFF
        do_reset();
        wr_a(16'd100);
        clk_sel = 3'd1;
        step(50);
        wr_a(16'd10);
        step(65535 - 51);
        chk("R5 reaches max", count, 16'hFFFF);
        chk("R5 no match yet", flag_cmpa, 0);
        chk("R6 ovf not yet", flag_ovf, 0);
        step(1);
        chk("R6 wrap count", count, 0);
        chk("R6 ovf set", flag_ovf, 1);
        step(10);
        chk("R5 count at top", count, 10);
        chk("R5 flag before match", flag_cmpa, 0);
        step(1);
        chk("R5 match after wrap", count, 0);
        chk("R5 flag after wrap", flag_cmpa, 1);
        flag_clr = 3'b100; step(1); flag_clr = 3'b000;
        chk("R11 ovf cleared", flag_ovf, 0);
        chk("R11 cmpa kept", flag_cmpa, 1);

        // R9 R10: fast PWM with TOP 9, duty 3, then buffered TOP 4
        do_reset();
        wr_a(16'd9);
        duty_b = 16'd3;
        mode = 2'b10;
        out_en = 1'b1;
        clk_sel = 3'd1;
        for (int k = 1; k <= 25; k++) begin
            step(1);
            chk("R3 pwm count", count, k % 10);
            chk("R10 pwm pin", wave_out, (k >= 10 && (k % 10) <= 3) ? 1 : 0);
        end
        wr_a(16'd4);
        chk("R9 count after buffered write", count, 6);
        step(2);
        chk("R9 old top still active", count, 8);
        step(2);
        chk("R9 wrap at old top", count, 0);
        chk("R10 set at wrap", wave_out, 1);
        step(4);
        chk("R9 new top reached", count, 4);
        chk("R10 low above duty", wave_out, 0);
        step(1);
        chk("R9 wrap at new top", count, 0);

        // R1: divider rates
        for (int s = 2; s <= 5; s++) begin
            int n;
            n = (s == 2) ? 8 : (s == 3) ? 64 : (s == 4) ? 256 : 1024;
            do_reset();
            wr_a(16'hFFFF);
            clk_sel = 3'(s);
            step(n - 1);
            chk("R1 before first tick", count, 0);
            step(1);
            chk("R1 first tick", count, 1);
            step(2 * n - 1);
            chk("R1 before third tick", count, 2);
            step(1);
            chk("R1 third tick", count, 3);
        end

        // R2: stopped selections
        do_reset();
        wr_a(16'd3);
        clk_sel = 3'd1;
        step(2);
        clk_sel = 3'd0;
        step(20);
        chk("R2 hold sel0", count, 2);
        clk_sel = 3'd6;
        step(5);
        chk("R2 hold sel6", count, 2);
        clk_sel = 3'd7;
        step(5);
        chk("R2 hold sel7", count, 2);
        chk("R2 no flags", {flag_ovf, flag_top_cap, flag_cmpa}, 0);
        clk_sel = 3'd1;
        step(2);
        chk("R2 resume", count, 0);
        chk("R2 flag after resume", flag_cmpa, 1);

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        done = 1;
        $finish;
    end
endmodule